// File: doc/BRIEF.md
# FIFO Burst Request Controller

This block sits beside one audio channel's local FIFO and decides when that FIFO should ask the system bus for a transfer, and how many dwords the transfer carries. Each instance serves one direction, picked by a mode input. When the FIFO drains toward the bus (write mode), the block looks at how many valid dwords are waiting. When the FIFO fills from the bus (read mode), it looks at how many empty dword slots remain.

Two small codes set the policy. A 3-bit burst code chooses the preferred burst size. A 2-bit threshold code chooses how much data or space must be present before a request is made. Once the block raises a request, it keeps it up until the bus grants it. It then waits for one word strobe per dword of the burst before it judges the FIFO again. The FIFO storage, the bus handshake beyond grant and strobe, and address generation belong to other blocks.

Top module: `brc_req_ctrl`

## Requirements
- R1: Burst code n (0 to 7) selects a preferred burst of 2^n dwords, so 0 gives 1 and 7 gives 128.
- R2: Threshold code 0, 1, 2 or 3 selects a threshold of 1, 4, 8 or 16 dwords.
- R3: With `rd_mode` = 0, a request rises only when `fifo_level` is at least the threshold.
- R4: With `rd_mode` = 1, a request rises only when FIFO_DEPTH minus `fifo_level` is at least the threshold.
- R5: `burst_len` presented with a request is the smaller of the preferred burst and the available count (valid dwords in write mode, free slots in read mode).
- R6: Once raised, `req` stays high with `burst_len` unchanged until `bus_grant` is seen high at a clock edge.
- R7: After the grant edge, `req` stays low until exactly `burst_len` word strobes have been counted. Strobes that arrive while not transferring are ignored.
- R8: The codes and the level are sampled only while idle. Changing them while a request is pending does not alter `burst_len`, and the new codes apply to the next request.
- R9: A synchronous active-low reset drops `req`, sets `burst_len` to 0 and abandons any burst in progress.
- R10: When FIFO_DEPTH is below 128, any preferred burst larger than FIFO_DEPTH is clamped to FIFO_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_mode | input | 1 | 0: FIFO to bus (count valid dwords); 1: bus to FIFO (count free slots) |
| burst_code | input | 3 | Preferred burst size code |
| thresh_code | input | 2 | Request threshold code |
| fifo_level | input | LVL_W | Dwords currently held in the FIFO |
| bus_grant | input | 1 | Bus accepts the pending request |
| word_strobe | input | 1 | One dword moved on the bus |
| req | output | 1 | Transfer request |
| burst_len | output | LEN_W | Dwords in the requested or active burst |

## Verification
The hardest situation to reach is a pending request whose inputs change under it. The bench holds back the grant for several cycles and, while it waits, rewrites the codes, lowers the level and pulses the word strobe. It then checks that the length did not move, that the stray strobe did not shorten the burst, and that the new codes appear only on the following request. A reset in the middle of a granted burst is forced the same way, after two of four strobes. A second instance with a 64-dword FIFO covers the clamp.

// File: rtl/brc_pkg.sv
package brc_pkg;

   typedef enum logic [1:0] {
      BRC_IDLE = 2'd0,
      BRC_ASK  = 2'd1,
      BRC_MOVE = 2'd2
   } brc_state_e;

   localparam int BRC_CODED_MAX  = 128;
   localparam int BRC_THRESH_MAX = 16;
   localparam int BRC_RAW_W      = 8;

   // threshold in dwords: 1, 4, 8, 16
   function automatic int brc_thresh_words(input logic [1:0] code);
      return (code == 2'd0) ? 1 : (2 << code);
   endfunction

   function automatic int brc_cap(input int depth);
      return (depth < BRC_CODED_MAX) ? depth : BRC_CODED_MAX;
   endfunction

endpackage

// File: rtl/brc_code_decode.sv
module brc_code_decode #(
   parameter int FIFO_DEPTH = 256,
   parameter int LEN_W      = 8
) (
   input  logic [2:0]       burst_code,
   input  logic [1:0]       thresh_code,
   output logic [LEN_W-1:0] burst_words,
   output logic [LEN_W-1:0] thresh_words
);
   import brc_pkg::*;

   localparam int CAP = brc_cap(FIFO_DEPTH);

   logic [BRC_RAW_W-1:0] raw_words;

   assign raw_words    = BRC_RAW_W'(1) << burst_code;
   assign thresh_words = LEN_W'(brc_thresh_words(thresh_code));

   generate
      if (FIFO_DEPTH >= BRC_CODED_MAX) begin : g_full
         assign burst_words = LEN_W'(raw_words);
      end else begin : g_clamp
         assign burst_words = (raw_words > BRC_RAW_W'(CAP)) ? LEN_W'(CAP)
                                                            : LEN_W'(raw_words);
      end
   endgenerate

endmodule

// File: rtl/brc_space_calc.sv
module brc_space_calc #(
   parameter int FIFO_DEPTH = 256,
   parameter int LVL_W      = 9
) (
   input  logic             rd_mode,
   input  logic [LVL_W-1:0] level,
   output logic [LVL_W-1:0] avail
);
   localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(FIFO_DEPTH);

   logic [LVL_W-1:0] free_slots;
   logic [LVL_W-1:0] valid_words;

   assign free_slots  = (level >= DEPTH_V) ? '0 : (DEPTH_V - level);
   assign valid_words = (level > DEPTH_V) ? DEPTH_V : level;
   assign avail       = rd_mode ? free_slots : valid_words;

endmodule

// File: rtl/brc_word_counter.sv
module brc_word_counter #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             step,
   output logic             last
);
   logic [LEN_W-1:0] remaining_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remaining_q <= '0;
      end else if (load) begin
         remaining_q <= load_val;
      end else if (step && (remaining_q != '0)) begin
         remaining_q <= remaining_q - LEN_W'(1);
      end
   end

   assign last = step && (remaining_q == LEN_W'(1));

endmodule

// File: rtl/brc_req_ctrl.sv
module brc_req_ctrl #(
   parameter  int FIFO_DEPTH = 256,
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
   localparam int LEN_W      = $clog2(brc_pkg::brc_cap(FIFO_DEPTH) + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_mode,
   input  logic [2:0]       burst_code,
   input  logic [1:0]       thresh_code,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic             bus_grant,
   input  logic             word_strobe,
   output logic             req,
   output logic [LEN_W-1:0] burst_len
);
   import brc_pkg::*;

   localparam int CMP_W = (LVL_W > LEN_W) ? LVL_W : LEN_W;

   generate
      if (FIFO_DEPTH < BRC_THRESH_MAX) begin : g_bad_depth
         $error("brc_req_ctrl: FIFO_DEPTH must hold the largest threshold");
      end
   endgenerate

   brc_state_e       state_q;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] burst_words;
   logic [LEN_W-1:0] thresh_words;
   logic [LVL_W-1:0] avail;
   logic [CMP_W-1:0] avail_x;
   logic [CMP_W-1:0] burst_x;
   logic [CMP_W-1:0] thresh_x;
   logic             qualify;
   logic [LEN_W-1:0] issue_len;
   logic             cnt_load;
   logic             cnt_step;
   logic             cnt_last;

   brc_code_decode #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .LEN_W      (LEN_W)
   ) u_decode (
      .burst_code   (burst_code),
      .thresh_code  (thresh_code),
      .burst_words  (burst_words),
      .thresh_words (thresh_words)
   );

   brc_space_calc #(
      .FIFO_DEPTH (FIFO_DEPTH),
      .LVL_W      (LVL_W)
   ) u_space (
      .rd_mode (rd_mode),
      .level   (fifo_level),
      .avail   (avail)
   );

   assign avail_x   = CMP_W'(avail);
   assign burst_x   = CMP_W'(burst_words);
   assign thresh_x  = CMP_W'(thresh_words);
   assign qualify   = (avail_x >= thresh_x);
   assign issue_len = (avail_x < burst_x) ? LEN_W'(avail_x) : burst_words;

   assign cnt_load = (state_q == BRC_ASK) && bus_grant;
   assign cnt_step = (state_q == BRC_MOVE) && word_strobe;

   brc_word_counter #(
      .LEN_W (LEN_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (len_q),
      .step     (cnt_step),
      .last     (cnt_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= BRC_IDLE;
         len_q   <= '0;
      end else begin
         case (state_q)
            BRC_IDLE: begin
               if (qualify) begin
                  state_q <= BRC_ASK;
                  len_q   <= issue_len;
               end
            end
            BRC_ASK: begin
               if (bus_grant) begin
                  state_q <= BRC_MOVE;
               end
            end
            BRC_MOVE: begin
               if (cnt_last) begin
                  state_q <= BRC_IDLE;
               end
            end
            default: state_q <= BRC_IDLE;
         endcase
      end
   end

   assign req       = (state_q == BRC_ASK);
   assign burst_len = len_q;

endmodule

// File: rtl/brc_req_ctrl_chk.sv
module brc_req_ctrl_chk #(
   parameter int FIFO_DEPTH = 256,
   parameter int LVL_W      = 9,
   parameter int LEN_W      = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_mode,
   input logic [2:0]       burst_code,
   input logic [1:0]       thresh_code,
   input logic [LVL_W-1:0] fifo_level,
   input logic             bus_grant,
   input logic             word_strobe,
   input logic             req,
   input logic [LEN_W-1:0] burst_len
);
   function automatic int room(input logic d, input int lvl);
      if (d) return (lvl >= FIFO_DEPTH) ? 0 : FIFO_DEPTH - lvl;
      return lvl;
   endfunction

   function automatic int limit(input logic [1:0] c);
      case (c)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 16;
      endcase
   endfunction

   logic             busy_q;
   logic [LEN_W-1:0] seen_q;
   logic [LEN_W-1:0] want_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         seen_q <= '0;
         want_q <= '0;
      end else if (req && bus_grant) begin
         busy_q <= 1'b1;
         seen_q <= '0;
         want_q <= burst_len;
      end else if (busy_q && word_strobe) begin
         if (seen_q + LEN_W'(1) == want_q) busy_q <= 1'b0;
         seen_q <= seen_q + LEN_W'(1);
      end
   end

   // R3 and R4: a new request needs enough data or space
   assert_req_needs_room_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> (room($past(rd_mode), int'($past(fifo_level)))
                      >= limit($past(thresh_code))));

   // R5 and R1: issued length bounded by available count and coded burst
   assert_len_bounded_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> ((int'(burst_len) <= room($past(rd_mode), int'($past(fifo_level))))
                      && (int'(burst_len) <= (1 << $past(burst_code)))
                      && (burst_len != '0)));

   assert_req_held_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (req && !bus_grant) |=> (req && $stable(burst_len)));

   assert_req_drops_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (req && bus_grant) |=> !req);

   assert_quiet_in_burst_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !req);

endmodule

bind brc_req_ctrl brc_req_ctrl_chk #(
   .FIFO_DEPTH (FIFO_DEPTH),
   .LVL_W      (LVL_W),
   .LEN_W      (LEN_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_mode     (rd_mode),
   .burst_code  (burst_code),
   .thresh_code (thresh_code),
   .fifo_level  (fifo_level),
   .bus_grant   (bus_grant),
   .word_strobe (word_strobe),
   .req         (req),
   .burst_len   (burst_len)
);

// File: tb/brc_req_ctrl_test.sv
`timescale 1ns/1ps
module brc_req_ctrl_test;

   localparam int DEPTH   = 256;
   localparam int LVL_W   = 9;
   localparam int LEN_W   = 8;
   localparam int S_DEPTH = 64;
   localparam int S_LVL_W = 7;
   localparam int S_LEN_W = 7;
   localparam int NVEC    = 15;

   // {rd_mode, burst_code, thresh_code, level[8:0], exp_req, exp_len[7:0]}
   localparam logic [23:0] TBL [NVEC] = '{
      {1'b0, 3'd0, 2'd0, 9'd0,   1'b0, 8'd0},
      {1'b0, 3'd0, 2'd0, 9'd1,   1'b1, 8'd1},
      {1'b0, 3'd2, 2'd1, 9'd3,   1'b0, 8'd0},
      {1'b0, 3'd2, 2'd1, 9'd4,   1'b1, 8'd4},
      {1'b0, 3'd3, 2'd1, 9'd5,   1'b1, 8'd5},
      {1'b0, 3'd7, 2'd3, 9'd200, 1'b1, 8'd128},
      {1'b0, 3'd7, 2'd3, 9'd15,  1'b0, 8'd0},
      {1'b0, 3'd5, 2'd2, 9'd100, 1'b1, 8'd32},
      {1'b0, 3'd1, 2'd2, 9'd8,   1'b1, 8'd2},
      {1'b1, 3'd4, 2'd3, 9'd241, 1'b0, 8'd0},
      {1'b1, 3'd4, 2'd3, 9'd240, 1'b1, 8'd16},
      {1'b1, 3'd6, 2'd0, 9'd250, 1'b1, 8'd6},
      {1'b1, 3'd7, 2'd0, 9'd0,   1'b1, 8'd128},
      {1'b1, 3'd3, 2'd2, 9'd256, 1'b0, 8'd0},
      {1'b1, 3'd6, 2'd2, 9'd200, 1'b1, 8'd56}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rd_mode = 1'b0;
   logic [2:0]       burst_code = '0;
   logic [1:0]       thresh_code = '0;
   logic [LVL_W-1:0] fifo_level = '0;
   logic             bus_grant = 1'b0;
   logic             word_strobe = 1'b0;
   logic             req;
   logic [LEN_W-1:0] burst_len;

   logic [2:0]         s_burst_code = '0;
   logic [1:0]         s_thresh_code = '0;
   logic [S_LVL_W-1:0] s_fifo_level = '0;
   logic               s_req;
   logic [S_LEN_W-1:0] s_burst_len;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   brc_req_ctrl #(.FIFO_DEPTH(DEPTH)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_mode     (rd_mode),
      .burst_code  (burst_code),
      .thresh_code (thresh_code),
      .fifo_level  (fifo_level),
      .bus_grant   (bus_grant),
      .word_strobe (word_strobe),
      .req         (req),
      .burst_len   (burst_len)
   );

   brc_req_ctrl #(.FIFO_DEPTH(S_DEPTH)) uut_small (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_mode     (1'b0),
      .burst_code  (s_burst_code),
      .thresh_code (s_thresh_code),
      .fifo_level  (s_fifo_level),
      .bus_grant   (1'b0),
      .word_strobe (1'b0),
      .req         (s_req),
      .burst_len   (s_burst_len)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic apply(input logic d, input logic [2:0] b, input logic [1:0] t,
                        input int lvl);
      rd_mode     = d;
      burst_code  = b;
      thresh_code = t;
      fifo_level  = LVL_W'(lvl);
   endtask

   // grant at the current negedge, then n strobes; req must stay low
   task automatic run_burst(input int n, input string tag);
      bus_grant = 1'b1;
      @(negedge clk);
      bus_grant = 1'b0;
      check(req == 1'b0, tag, int'(req), 0);
      for (int i = 0; i < n; i++) begin
         word_strobe = 1'b1;
         @(negedge clk);
         if (req !== 1'b0) check(1'b0, tag, int'(req), 0);
      end
      word_strobe = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // reset state, R9
      repeat (3) @(negedge clk);
      check(req == 1'b0, "R9 reset req", int'(req), 0);
      check(burst_len == '0, "R9 reset len", int'(burst_len), 0);
      rst_n = 1'b1;

      // table: R1 R2 R3 R4 R5 R7
      for (int v = 0; v < NVEC; v++) begin
         logic [23:0] e;
         e = TBL[v];
         apply(e[23], e[22:20], e[19:18], int'(e[17:9]));
         @(negedge clk);
         check(req == e[8], $sformatf("R3/R4 vector %0d req", v), int'(req), int'(e[8]));
         if (e[8]) begin
            check(burst_len == e[7:0], $sformatf("R1/R2/R5 vector %0d len", v),
                  int'(burst_len), int'(e[7:0]));
            run_burst(int'(e[7:0]), "R7 burst quiet");
         end
      end
      apply(1'b0, 3'd0, 2'd0, 0);
      @(negedge clk);

      // R6 and R8: pending request ignores code and level changes
      apply(1'b0, 3'd7, 2'd3, 200);
      @(negedge clk);
      check(req == 1'b1 && burst_len == 8'd128, "R6 raise", int'(burst_len), 128);
      apply(1'b0, 3'd0, 2'd0, 20);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check(req == 1'b1, "R6 held without grant", int'(req), 1);
         check(burst_len == 8'd128, "R8 len frozen", int'(burst_len), 128);
      end
      word_strobe = 1'b1;
      @(negedge clk);
      word_strobe = 1'b0;
      check(req == 1'b1, "R7 stray strobe ignored", int'(req), 1);
      run_burst(128, "R7 long burst quiet");
      check(req == 1'b0, "R7 idle after last strobe", int'(req), 0);
      @(negedge clk);
      check(req == 1'b1 && burst_len == 8'd1, "R8 new code applies", int'(burst_len), 1);
      run_burst(1, "R7 single");
      apply(1'b0, 3'd0, 2'd0, 0);
      @(negedge clk);

      // R9: reset inside a granted burst
      apply(1'b0, 3'd2, 2'd0, 50);
      @(negedge clk);
      check(req == 1'b1 && burst_len == 8'd4, "R9 pre-reset req", int'(burst_len), 4);
      bus_grant = 1'b1;
      @(negedge clk);
      bus_grant   = 1'b0;
      word_strobe = 1'b1;
      repeat (2) @(negedge clk);
      word_strobe = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check(req == 1'b0, "R9 mid-burst reset req", int'(req), 0);
      check(burst_len == '0, "R9 mid-burst reset len", int'(burst_len), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req == 1'b1 && burst_len == 8'd4, "R9 fresh request", int'(burst_len), 4);
      run_burst(4, "R9 fresh burst quiet");
      apply(1'b0, 3'd0, 2'd0, 0);
      @(negedge clk);
      check(req == 1'b0, "R3 empty stays idle", int'(req), 0);

      // R10: small FIFO clamps the coded burst
      s_burst_code  = 3'd7;
      s_thresh_code = 2'd3;
      s_fifo_level  = S_LVL_W'(S_DEPTH);
      @(negedge clk);
      check(s_req == 1'b1, "R10 small req", int'(s_req), 1);
      check(s_burst_len == S_LEN_W'(S_DEPTH), "R10 clamp", int'(s_burst_len), S_DEPTH);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule